// File: doc/BRIEF.md
# Decoder Control and Error-Count Registers

This block is the small register bank that sits beside an optical-disc channel decoder. Software writes one byte to set the decoder's operating mode. The upper seven bits pick the mode. The lowest bit is a kill switch that holds the laser enable and the write enable inactive. The block decodes the mode into steady control levels for the rest of the decoder: a flush/discard level, a four-pass correction select, a FIFO write inhibit, a header-decode inhibit and an encode select.

The block also keeps two eight-bit error counters, one for first-stage (C1) frames and one for second-stage (C2) frames that the corrector reports as damaged. Each counter stops at its maximum instead of wrapping. Reading a counter returns its value and empties it, so software only ever sees events since its last read. A single-cycle read strobe and a single-cycle write strobe share one address bus.

Top module: `dec_regs`

## Requirements
- R1: After reset the mode byte is 0x01: flush mode with laser and write forced off. Both counters are zero, and the read data register is 0x00.
- R2: A write to address 0x13 loads the mode byte, and the new outputs appear after that clock edge. A write to any other address changes nothing. Mode byte bit 0 = 1 forces laserOn and writeOn to 0. With bit 0 = 0, they follow laserReq and writeReq.
- R3: Mode field 7'h00 (flush) asserts flushActive and hdrDecodeInhibit. The other mode outputs stay low.
- R4: Mode field 7'h08 (normal play) asserts fourPassSel alone. Mode field 7'h28 (fast play) deasserts fourPassSel, and every mode output is low.
- R5: Mode field 7'h18 (hold) asserts fifoWrInhibit and leaves hdrDecodeInhibit low. Any mode field not listed in R3 to R6 behaves exactly as hold.
- R6: Mode field 7'h30 (encode) asserts encodeActive and hdrDecodeInhibit. The other mode outputs stay low.
- R7: Each cycle with c1ErrPulse high adds one to the C1 counter. A read strobe at address 0x39 places that count on regRdData after the clock edge.
- R8: Each cycle with c2ErrPulse high adds one to the C2 counter. A read strobe at address 0x3A returns that count.
- R9: A counter at 255 stays at 255 when more error pulses arrive.
- R10: Reading a counter clears it to zero. If an error pulse arrives in the same cycle as the read, the read returns the old value and the counter restarts at 1.
- R11: A read of any address other than 0x39 or 0x3A returns 0x00. This includes the write-only mode address 0x13, and such a read leaves both counters untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 8 | Registered read data |
| c1ErrPulse | input | 1 | One C1 frame with errors |
| c2ErrPulse | input | 1 | One C2 frame with errors |
| laserReq | input | 1 | Internal laser-on request |
| writeReq | input | 1 | Internal write-on request |
| laserOn | output | 1 | Gated laser enable |
| writeOn | output | 1 | Gated write enable |
| flushActive | output | 1 | Empty deinterleaver, discard data |
| fourPassSel | output | 1 | 1 = four-pass correction, 0 = two-pass |
| fifoWrInhibit | output | 1 | Stop writes into the output FIFO |
| hdrDecodeInhibit | output | 1 | Stop header/subheader decoding |
| encodeActive | output | 1 | Encode mode selected |

## Verification
A write strobe acts at one clock edge, so the mode outputs and the gated enables are due just after that same edge. The bench drives each strobe for exactly one edge and samples a moment later. A read's data is registered, so it appears after the edge that takes the strobe, and the clear acts at that same edge. The bench therefore checks read data one edge after raising the strobe, and checks the clear with a second read. Error pulses are counted one per edge, so a burst of N high cycles must read back as N, or as 255 once N reaches past saturation.

// File: rtl/dec_regs_pkg.sv
package dec_regs_pkg;
  localparam int MODE_W  = 7;
  localparam int NUM_CNT = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_FLUSH  = 7'h00,
    MODE_NORMAL = 7'h08,
    MODE_HOLD   = 7'h18,
    MODE_FAST   = 7'h28,
    MODE_ENCODE = 7'h30
  } decMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_CNT-1:0] rdHit;
    logic               forceOff;
    logic               flush;
    logic               fourPass;
    logic               fifoInhibit;
    logic               hdrInhibit;
    logic               encode;
  } ctrlStrobes_t;
endpackage

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import dec_regs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h13,
  parameter logic [ADDR_W-1:0] CNT_BASE  = 8'h39,
  parameter logic [DATA_W-1:0] MODE_RST  = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output ctrlStrobes_t      strb
);
  logic [DATA_W-1:0] modeReg;
  logic [MODE_W-1:0] modeField;
  logic              modeWr;

  assign modeWr    = regWrEn && (regAddr == MODE_ADDR);
  assign modeField = modeReg[DATA_W-1:1];

  always_ff @(posedge clk) begin
    if (!rstN)       modeReg <= MODE_RST;
    else if (modeWr) modeReg <= regWrData;
  end

  always_comb begin
    strb.forceOff    = modeReg[0];
    strb.flush       = 1'b0;
    strb.fourPass    = 1'b0;
    strb.fifoInhibit = 1'b0;
    strb.hdrInhibit  = 1'b0;
    strb.encode      = 1'b0;
    case (modeField)
      MODE_FLUSH: begin
        strb.flush      = 1'b1;
        strb.hdrInhibit = 1'b1;
      end
      MODE_NORMAL: strb.fourPass = 1'b1;
      MODE_FAST:   strb.fourPass = 1'b0;
      MODE_ENCODE: begin
        strb.encode     = 1'b1;
        strb.hdrInhibit = 1'b1;
      end
      default: strb.fifoInhibit = 1'b1; // hold and reserved
    endcase
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_rdHit
    assign strb.rdHit[i] = regRdEn && (regAddr == ADDR_W'(CNT_BASE + i));
  end
endmodule

// File: rtl/dec_datapath.sv
module dec_datapath
  import dec_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strb,
  input  logic [NUM_CNT-1:0]            errPulse,
  input  logic                          laserReq,
  input  logic                          writeReq,
  output logic                          laserOn,
  output logic                          writeOn,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  output logic [DATA_W-1:0]             rdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] baseVal;
    assign baseVal = strb.rdHit[i] ? '0 : cntVal[i];
    always_ff @(posedge clk) begin
      if (!rstN)
        cntVal[i] <= '0;
      else if (errPulse[i] && baseVal != CNT_MAX)
        cntVal[i] <= baseVal + 1'b1;
      else
        cntVal[i] <= baseVal;
    end
  end

  logic [DATA_W-1:0] rdMux;
  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (strb.rdHit[i]) rdMux = DATA_W'(cntVal[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdMux;
  end

  assign laserOn = laserReq && !strb.forceOff;
  assign writeOn = writeReq && !strb.forceOff;
endmodule

// File: rtl/dec_regs.sv
module dec_regs
  import dec_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData,
  input  logic              c1ErrPulse,
  input  logic              c2ErrPulse,
  input  logic              laserReq,
  input  logic              writeReq,
  output logic              laserOn,
  output logic              writeOn,
  output logic              flushActive,
  output logic              fourPassSel,
  output logic              fifoWrInhibit,
  output logic              hdrDecodeInhibit,
  output logic              encodeActive
);
  ctrlStrobes_t                  strb;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CNT-1:0]            rdHitVec;

  dec_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .strb(strb)
  );

  dec_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .errPulse({c2ErrPulse, c1ErrPulse}),
    .laserReq(laserReq), .writeReq(writeReq),
    .laserOn(laserOn), .writeOn(writeOn),
    .cntVal(cntVal), .rdData(regRdData)
  );

  assign rdHitVec         = strb.rdHit;
  assign flushActive      = strb.flush;
  assign fourPassSel      = strb.fourPass;
  assign fifoWrInhibit    = strb.fifoInhibit;
  assign hdrDecodeInhibit = strb.hdrInhibit;
  assign encodeActive     = strb.encode;
endmodule

// File: rtl/dec_regs_chk.sv
module dec_regs_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regAddr,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic       regRdEn,
  input logic [7:0] regRdData,
  input logic       c1ErrPulse,
  input logic [1:0] rdHit,
  input logic [7:0] c1Cnt,
  input logic       laserOn,
  input logic       writeOn,
  input logic       flushActive,
  input logic       fourPassSel,
  input logic       fifoWrInhibit,
  input logic       encodeActive
);
  // R2
  force_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h13 && regWrData[0]) |=> (!laserOn && !writeOn));
  // R3
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flushActive, fourPassSel, fifoWrInhibit, encodeActive}));
  // R7
  c1_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (c1ErrPulse && !rdHit[0] && c1Cnt != 8'hFF) |=> (c1Cnt == $past(c1Cnt) + 8'd1));
  // R9
  c1_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (c1Cnt == 8'hFF && !rdHit[0]) |=> (c1Cnt == 8'hFF));
  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit[0] && !c1ErrPulse) |=> (c1Cnt == 8'd0 && regRdData == $past(c1Cnt)));
  // R10
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit[0] && c1ErrPulse) |=> (c1Cnt == 8'd1));
  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr != 8'h39 && regAddr != 8'h3A) |=> (regRdData == 8'h00));
endmodule

bind dec_regs dec_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
  .c1ErrPulse(c1ErrPulse), .rdHit(rdHitVec), .c1Cnt(cntVal[0]),
  .laserOn(laserOn), .writeOn(writeOn), .flushActive(flushActive),
  .fourPassSel(fourPassSel), .fifoWrInhibit(fifoWrInhibit),
  .encodeActive(encodeActive)
);

// File: tb/tb_dec_regs.sv
module tb_dec_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic c1ErrPulse = 1'b0, c2ErrPulse = 1'b0;
  logic laserReq = 1'b1, writeReq = 1'b1;
  logic laserOn, writeOn, flushActive, fourPassSel, fifoWrInhibit, hdrDecodeInhibit, encodeActive;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_regs dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .c1ErrPulse(c1ErrPulse), .c2ErrPulse(c2ErrPulse),
    .laserReq(laserReq), .writeReq(writeReq),
    .laserOn(laserOn), .writeOn(writeOn), .flushActive(flushActive),
    .fourPassSel(fourPassSel), .fifoWrInhibit(fifoWrInhibit),
    .hdrDecodeInhibit(hdrDecodeInhibit), .encodeActive(encodeActive)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {flush, fourPass, fifoInhibit, hdrInhibit, encode}
  function automatic logic [4:0] modeVec();
    return {flushActive, fourPassSel, fifoWrInhibit, hdrDecodeInhibit, encodeActive};
  endfunction

  task automatic wrReg(logic [7:0] a, logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [7:0] d);
    regAddr = a; regRdEn = 1'b1;
    tick();
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic pulses(int n1, int n2);
    for (int i = 0; i < (n1 > n2 ? n1 : n2); i++) begin
      c1ErrPulse = (i < n1);
      c2ErrPulse = (i < n2);
      tick();
    end
    c1ErrPulse = 1'b0; c2ErrPulse = 1'b0;
  endtask

  task automatic testReset();
    check("R1 mode outputs", modeVec(), 5'b10010);
    check("R1 laser forced", {laserOn, writeOn}, 2'b00);
    check("R1 rdData", regRdData, 8'h00);
  endtask

  task automatic testModes();
    logic [7:0] d;
    wrReg(8'h13, 8'h10);
    check("R4 normal", modeVec(), 5'b01000);
    check("R2 laser follows", {laserOn, writeOn}, 2'b11);
    laserReq = 1'b0; #1;
    check("R2 laser follows req", {laserOn, writeOn}, 2'b01);
    laserReq = 1'b1;
    wrReg(8'h13, 8'h50);
    check("R4 fast", modeVec(), 5'b00000);
    wrReg(8'h13, 8'h30);
    check("R5 hold", modeVec(), 5'b00100);
    wrReg(8'h13, 8'hFE);
    check("R5 reserved as hold", modeVec(), 5'b00100);
    wrReg(8'h13, 8'h60);
    check("R6 encode", modeVec(), 5'b00011);
    wrReg(8'h13, 8'h01);
    check("R3 flush", modeVec(), 5'b10010);
    check("R2 forced off", {laserOn, writeOn}, 2'b00);
    wrReg(8'h13, 8'h11);
    check("R2 normal forced off", {laserOn, writeOn}, 2'b00);
    wrReg(8'h20, 8'h60);
    check("R2 other addr ignored", modeVec(), 5'b01000);
    rdReg(8'h13, d);
    check("R11 mode addr reads zero", d, 8'h00);
  endtask

  task automatic testCounters();
    logic [7:0] d;
    pulses(5, 3);
    rdReg(8'h55, d);
    check("R11 unmapped read", d, 8'h00);
    rdReg(8'h39, d);
    check("R7 c1 count", d, 8'd5);
    rdReg(8'h3A, d);
    check("R8 c2 count", d, 8'd3);
    rdReg(8'h39, d);
    check("R10 c1 cleared", d, 8'd0);
    pulses(0, 300);
    rdReg(8'h3A, d);
    check("R9 c2 saturate", d, 8'd255);
    pulses(260, 0);
    rdReg(8'h39, d);
    check("R9 c1 saturate", d, 8'd255);
    pulses(3, 0);
    regAddr = 8'h39; regRdEn = 1'b1; c1ErrPulse = 1'b1;
    tick();
    regRdEn = 1'b0; c1ErrPulse = 1'b0;
    check("R10 read with pulse returns old", regRdData, 8'd3);
    rdReg(8'h39, d);
    check("R10 restart at one", d, 8'd1);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testModes();
    testCounters();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule